// File: doc/BRIEF.md
# Peripheral Region Access Protection Checker

This block checks each access made on a peripheral bus against a set of access control registers. The access offset (taken from the peripheral base) is split into sixteen 64-Mbyte regions by its top four bits. Regions 0 and 1 each own an 8-bit region control register. Regions 2 to 15 are reserved, and any access to them is refused. Inside region 0, a row of per-module address windows each has its own control register. Where a window covers the address, that register alone decides the outcome and the region register is not consulted.

Each access is presented as a one-cycle strobe together with its offset, direction, privilege (supervisor or user) and an instruction-fetch flag. The decision is combinational. One cycle after the strobe it is returned on a registered response as either a grant or a bus error. A byte-wide register port writes and reads the control registers. Each register holds a lock bit that freezes it until the next reset.

Top module: `periph_guard`

## Requirements
- R1: After reset every control register reads 0x00 and `rsp_valid`, `rsp_ok` and `rsp_err` are low.
- R2: Offset bits [29:26] select the region. An access to regions 2 to 15 always gets `rsp_err`.
- R3: Region 0's register is at register offset 0x30 and region 1's is at 0x31. Module window i's register is at 0x20+i. A read returns {lock, 3'b000, code}. Bits 6:4 always read 0, and any other offset reads 0x00 and ignores writes.
- R4: Code table, with fetch needing execute permission and ignoring the write flag. In every defined code the supervisor may read and write. The supervisor may execute under codes 1, 3 and 5. The user may read under codes 2 to 5, write under 4 and 5, and execute under 3 and 5.
- R5: Codes 6 to 15 deny every access.
- R6: A write with bit 7 set stores the lock bit and the code in the same cycle. Later writes to a locked register are ignored until reset.
- R7: With default parameters, module window i (i = 0..3) covers offsets 0x10000*(i+1) to 0x10000*(i+1)+0xFFFF. Accesses there are decided by that window's register and not by region 0's register. The rest of region 0 uses region 0's register.
- R8: An instruction fetch into a module window always gets `rsp_err`, whatever the window's code.
- R9: After reset a module window allows supervisor read and write only (code 0).
- R10: `rsp_valid` is high for exactly the cycle after each `acc_valid` cycle. When it is high, exactly one of `rsp_ok` and `rsp_err` is high. When it is low, both are low. Register writes take effect for accesses in later cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 8 | Control register offset |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data (combinational) |
| acc_valid | input | 1 | Access check strobe |
| acc_addr | input | 30 | Access offset from the peripheral base |
| acc_write | input | 1 | Access is a write |
| acc_user | input | 1 | Access is in user mode |
| acc_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Response strobe, one cycle after acc_valid |
| rsp_ok | output | 1 | Access granted |
| rsp_err | output | 1 | Access terminated with a bus error |

## Verification
A wrong code or lock bit inside a register shows up at the ports in two ways. On the same cycle it appears through `reg_rdata`, once that offset is addressed. On the very next cycle it appears in the grant/error of any access routed to that register. A window decode error shows up as a grant pattern that follows the region 0 code instead of the module's code, one cycle after the strobe. A stuck response register breaks the strict one-cycle pairing between `acc_valid` and `rsp_valid` at the first idle cycle.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

   localparam int CODE_W   = 4;
   localparam int CTRL_W   = 8;
   localparam int LOCK_BIT = 7;

   typedef struct packed {
      logic sup_rd;
      logic sup_wr;
      logic sup_ex;
      logic usr_rd;
      logic usr_wr;
      logic usr_ex;
   } pgd_perm_t;

   // Maps a 4-bit access code onto separate supervisor and user permissions.
   function automatic pgd_perm_t pgd_code_perm(input logic [CODE_W-1:0] code);
      pgd_perm_t p;
      case (code)
         4'd0:    p = pgd_perm_t'(6'b110_000);
         4'd1:    p = pgd_perm_t'(6'b111_000);
         4'd2:    p = pgd_perm_t'(6'b110_100);
         4'd3:    p = pgd_perm_t'(6'b111_101);
         4'd4:    p = pgd_perm_t'(6'b110_110);
         4'd5:    p = pgd_perm_t'(6'b111_111);
         default: p = pgd_perm_t'(6'b000_000);
      endcase
      return p;
   endfunction

endpackage

// File: rtl/pgd_ctrl_regs.sv
module pgd_ctrl_regs
   import pgd_pkg::*;
#(
   parameter int NUM_REGION_REGS = 2,
   parameter int NUM_MODULES     = 4,
   parameter int REGION_REG_BASE = 'h30,
   parameter int MOD_REG_BASE    = 'h20
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [7:0]                            addr,
   input  logic [CTRL_W-1:0]                     wdata,
   output logic [CTRL_W-1:0]                     rdata,
   output logic [NUM_REGION_REGS-1:0][CODE_W-1:0] region_code,
   output logic [NUM_MODULES-1:0][CODE_W-1:0]     mod_code
);

   localparam int NREG = NUM_REGION_REGS + NUM_MODULES;

   if (REGION_REG_BASE + NUM_REGION_REGS > 256 || MOD_REG_BASE + NUM_MODULES > 256) begin : g_bad_range
      $error("pgd_ctrl_regs: register offsets exceed the 8-bit register space");
   end
   if (MOD_REG_BASE < REGION_REG_BASE + NUM_REGION_REGS &&
       REGION_REG_BASE < MOD_REG_BASE + NUM_MODULES) begin : g_bad_overlap
      $error("pgd_ctrl_regs: module and region register offsets overlap");
   end

   logic [NREG-1:0]             hit;
   logic [NREG-1:0]             lock_q;
   logic [NREG-1:0][CODE_W-1:0] code_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int OFF = (i < NUM_REGION_REGS) ? REGION_REG_BASE + i
                                                 : MOD_REG_BASE + (i - NUM_REGION_REGS);

      assign hit[i] = (addr == 8'(OFF));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lock_q[i] <= 1'b0;
            code_q[i] <= '0;
         end else if (wr_en && hit[i] && !lock_q[i]) begin
            lock_q[i] <= wdata[LOCK_BIT];
            code_q[i] <= wdata[CODE_W-1:0];
         end
      end

      // R6: a locked register keeps both its code and its lock until reset
      a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         lock_q[i] |=> (lock_q[i] && $stable(code_q[i])));

      if (i < NUM_REGION_REGS) begin : g_region
         assign region_code[i] = code_q[i];
      end else begin : g_module
         assign mod_code[i-NUM_REGION_REGS] = code_q[i];
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) rdata = {lock_q[i], 3'b000, code_q[i]};
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata[LOCK_BIT-1:CODE_W];

   // R3: an offset that matches no register never yields nonzero read data
   a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (rdata == '0));

endmodule

// File: rtl/pgd_decode.sv
module pgd_decode
   import pgd_pkg::*;
#(
   parameter int REGION_W        = 4,
   parameter int WIN_W           = 10,
   parameter int NUM_REGION_REGS = 2,
   parameter int NUM_MODULES     = 4,
   parameter int MOD_FIRST_WIN   = 1
) (
   input  logic [REGION_W-1:0]                    region,
   input  logic [WIN_W-1:0]                       win,
   input  logic [NUM_REGION_REGS-1:0][CODE_W-1:0] region_code,
   input  logic [NUM_MODULES-1:0][CODE_W-1:0]     mod_code,
   output logic [CODE_W-1:0]                      sel_code,
   output logic                                   mod_hit,
   output logic                                   reserved
);

   if (MOD_FIRST_WIN + NUM_MODULES > (1 << WIN_W)) begin : g_bad_win
      $error("pgd_decode: module windows do not fit inside region 0");
   end
   if (NUM_REGION_REGS < 1 || NUM_REGION_REGS > (1 << REGION_W)) begin : g_bad_regions
      $error("pgd_decode: region register count out of range");
   end

   logic [NUM_MODULES-1:0] win_hit;

   for (genvar i = 0; i < NUM_MODULES; i++) begin : g_win
      assign win_hit[i] = (region == '0) && (win == WIN_W'(MOD_FIRST_WIN + i));
   end

   assign mod_hit  = |win_hit;
   assign reserved = (32'(region) >= NUM_REGION_REGS);

   always_comb begin
      sel_code = '0;
      for (int r = 0; r < NUM_REGION_REGS; r++) begin
         if (region == REGION_W'(r)) sel_code = region_code[r];
      end
      for (int i = 0; i < NUM_MODULES; i++) begin
         if (win_hit[i]) sel_code = mod_code[i];
      end
   end

endmodule

// File: rtl/pgd_policy.sv
module pgd_policy
   import pgd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_user,
   input  logic              acc_fetch,
   input  logic [CODE_W-1:0] sel_code,
   input  logic              mod_hit,
   input  logic              reserved,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              rsp_err
);

   pgd_perm_t perm;
   logic      allow;

   always_comb begin
      perm = pgd_code_perm(sel_code);
      if (mod_hit) begin
         perm.sup_ex = 1'b0;
         perm.usr_ex = 1'b0;
      end
      if (reserved)       allow = 1'b0;
      else if (acc_fetch) allow = acc_user ? perm.usr_ex : perm.sup_ex;
      else if (acc_write) allow = acc_user ? perm.usr_wr : perm.sup_wr;
      else                allow = acc_user ? perm.usr_rd : perm.sup_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_ok    <= acc_valid && allow;
         rsp_err   <= acc_valid && !allow;
      end
   end

   // R10: response follows each strobe by exactly one cycle
   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);
   // R10: grant and error are exclusive and only present with a response
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid ? (rsp_ok != rsp_err) : (!rsp_ok && !rsp_err));
   // R2: reserved regions never grant
   a_r2_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && reserved) |=> rsp_err);
   // R8: fetch into a module window always errors
   a_r8_module_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && mod_hit && acc_fetch) |=> rsp_err);
   // R5: undefined codes grant nothing
   a_r5_undefined: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && sel_code > 4'd5) |=> rsp_err);

endmodule

// File: rtl/periph_guard.sv
module periph_guard
   import pgd_pkg::*;
#(
   parameter int ADDR_W          = 30,
   parameter int NUM_MODULES     = 4,
   parameter int MOD_WIN_LOG2    = 16,
   parameter int MOD_FIRST_WIN   = 1,
   parameter int MOD_REG_BASE    = 'h20,
   parameter int REGION_REG_BASE = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_user,
   input  logic              acc_fetch,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              rsp_err
);

   localparam int REGION_W        = 4;
   localparam int NUM_REGION_REGS = 2;
   localparam int REGION_LSB      = ADDR_W - REGION_W;
   localparam int WIN_W           = REGION_LSB - MOD_WIN_LOG2;

   if (WIN_W < 1 || MOD_WIN_LOG2 < 1) begin : g_bad_geom
      $error("periph_guard: module window size does not fit below the region field");
   end
   if (NUM_MODULES < 1) begin : g_bad_mods
      $error("periph_guard: at least one module window is required");
   end

   logic [NUM_REGION_REGS-1:0][CODE_W-1:0] region_code;
   logic [NUM_MODULES-1:0][CODE_W-1:0]     mod_code;
   logic [CODE_W-1:0]                      sel_code;
   logic                                   mod_hit;
   logic                                   reserved;

   pgd_ctrl_regs #(
      .NUM_REGION_REGS (NUM_REGION_REGS),
      .NUM_MODULES     (NUM_MODULES),
      .REGION_REG_BASE (REGION_REG_BASE),
      .MOD_REG_BASE    (MOD_REG_BASE)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rdata       (reg_rdata),
      .region_code (region_code),
      .mod_code    (mod_code)
   );

   pgd_decode #(
      .REGION_W        (REGION_W),
      .WIN_W           (WIN_W),
      .NUM_REGION_REGS (NUM_REGION_REGS),
      .NUM_MODULES     (NUM_MODULES),
      .MOD_FIRST_WIN   (MOD_FIRST_WIN)
   ) decode_i (
      .region      (acc_addr[ADDR_W-1:REGION_LSB]),
      .win         (acc_addr[REGION_LSB-1:MOD_WIN_LOG2]),
      .region_code (region_code),
      .mod_code    (mod_code),
      .sel_code    (sel_code),
      .mod_hit     (mod_hit),
      .reserved    (reserved)
   );

   pgd_policy policy_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_user  (acc_user),
      .acc_fetch (acc_fetch),
      .sel_code  (sel_code),
      .mod_hit   (mod_hit),
      .reserved  (reserved),
      .rsp_valid (rsp_valid),
      .rsp_ok    (rsp_ok),
      .rsp_err   (rsp_err)
   );

   logic unused_addr_lsbs;
   assign unused_addr_lsbs = ^acc_addr[MOD_WIN_LOG2-1:0];

endmodule

// File: tb/periph_guard_tb.sv
`timescale 1ns/1ps
module periph_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        acc_valid = 1'b0;
   logic [29:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_user = 1'b0;
   logic        acc_fetch = 1'b0;
   logic        rsp_valid, rsp_ok, rsp_err;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state: index 0,1 regions; 2..5 module windows 0..3
   int m_lock [6];
   int m_code [6];
   int e_valid = 0, e_ok = 0, e_err = 0;

   always #10 clk = ~clk;

   periph_guard dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_write(acc_write), .acc_user(acc_user),
      .acc_fetch(acc_fetch), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err)
   );

   function automatic int off_idx(input int off);
      if (off == 'h30) return 0;
      if (off == 'h31) return 1;
      if (off >= 'h20 && off <= 'h23) return off - 'h20 + 2;
      return -1;
   endfunction

   function automatic int model_read(input int off);
      int k = off_idx(off);
      if (k < 0) return 0;
      return m_lock[k] * 128 + m_code[k];
   endfunction

   function automatic int model_allow(input int a, input int w, input int u, input int f);
      int region = (a >> 26) & 15;
      int win    = (a >> 16) & 'h3FF;
      int c;
      bit is_mod = 0;
      if (region >= 2) return 0;
      if (region == 0 && win >= 1 && win <= 4) begin
         is_mod = 1;
         c = m_code[win + 1];
      end else begin
         c = m_code[region];
      end
      if (c > 5) return 0;
      if (f != 0) begin
         if (is_mod) return 0;
         if (u != 0) return (c == 3 || c == 5) ? 1 : 0;
         return (c == 1 || c == 3 || c == 5) ? 1 : 0;
      end
      if (u == 0) return 1;
      if (w != 0) return (c >= 4) ? 1 : 0;
      return (c >= 2) ? 1 : 0;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < 6; k++) begin
         m_lock[k] = 0;
         m_code[k] = 0;
      end
      e_valid = 0; e_ok = 0; e_err = 0;
   endtask

   // one clock: drive at negedge, check read data, advance model, check response
   task automatic step(input string tag, input bit wr, input int ra, input int wd,
                       input bit av, input int aa, input bit aw, input bit au, input bit af);
      int al;
      int k;
      reg_wr    = wr;
      reg_addr  = 8'(ra);
      reg_wdata = 8'(wd);
      acc_valid = av;
      acc_addr  = 30'(aa);
      acc_write = aw;
      acc_user  = au;
      acc_fetch = af;
      #1;
      check(tag, "reg_rdata", int'(reg_rdata), model_read(ra));
      @(posedge clk);
      al = model_allow(aa, aw, au, af);
      e_valid = av;
      e_ok    = av && al != 0;
      e_err   = av && al == 0;
      k = off_idx(ra);
      if (wr && k >= 0 && m_lock[k] == 0) begin
         m_lock[k] = (wd >> 7) & 1;
         m_code[k] = wd & 15;
      end
      @(negedge clk);
      check(tag, "rsp_valid", int'(rsp_valid), e_valid);
      check(tag, "rsp_ok",    int'(rsp_ok),    e_ok);
      check(tag, "rsp_err",   int'(rsp_err),   e_err);
   endtask

   task automatic acc(input string tag, input int aa, input bit aw, input bit au, input bit af);
      step(tag, 1'b0, 'h30, 0, 1'b1, aa, aw, au, af);
   endtask

   task automatic wreg(input string tag, input int ra, input int wd);
      step(tag, 1'b1, ra, wd, 1'b0, 0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic rd(input string tag, input int ra);
      step(tag, 1'b0, ra, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      reg_wr = 1'b0;
      acc_valid = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      model_clear();
      do_reset();

      // R1: reset contents and idle response
      rd("R1", 'h30); rd("R1", 'h31);
      for (int i = 0; i < 4; i++) rd("R1", 'h20 + i);

      // R9 / R4 with code 0 everywhere
      acc("R4", 'h100, 0, 0, 0);
      acc("R4", 'h100, 0, 1, 0);
      acc("R4", 'h100, 0, 0, 1);
      acc("R9", 'h10000, 1, 0, 0);
      acc("R9", 'h40004, 0, 1, 0);

      // R3: reserved bits read zero; R4 full access on region 0
      wreg("R3", 'h30, 'h75);
      rd("R3", 'h30);
      acc("R4", 'h200, 0, 1, 1);
      acc("R7", 'h50000, 1, 1, 0);
      acc("R7", 'h20000, 1, 1, 0);

      // R8: module fetch errors even with full-access code
      acc("R8", 'h20000, 0, 0, 1);
      wreg("R7", 'h21, 'h05);
      acc("R8", 'h20000, 0, 0, 1);
      acc("R8", 'h20000, 0, 1, 1);
      acc("R7", 'h20000, 1, 1, 0);
      acc("R7", 'h30000, 1, 1, 0);
      wreg("R7", 'h30, 'h00);
      acc("R7", 'h20010, 1, 1, 0);
      acc("R7", 'h60000, 1, 1, 0);

      // R2: reserved regions
      acc("R2", 'h0800_0000, 0, 0, 0);
      acc("R2", 'h3C00_0000, 1, 0, 0);
      acc("R2", 'h1000_0100, 0, 1, 1);

      // R4: code table on region 1
      acc("R4", 'h0400_0000, 0, 1, 0);
      wreg("R4", 'h31, 'h03);
      acc("R4", 'h0400_0000, 0, 1, 0);
      acc("R4", 'h0400_0000, 1, 1, 0);
      acc("R4", 'h0400_0000, 1, 1, 1);
      acc("R4", 'h0400_0000, 0, 0, 1);
      wreg("R4", 'h31, 'h02);
      acc("R4", 'h0400_0040, 0, 1, 0);
      acc("R4", 'h0400_0040, 1, 1, 0);
      acc("R4", 'h0400_0040, 0, 1, 1);
      wreg("R4", 'h31, 'h04);
      acc("R4", 'h0410_0000, 1, 1, 0);
      acc("R4", 'h0410_0000, 0, 1, 1);
      wreg("R4", 'h31, 'h01);
      acc("R4", 'h0400_0000, 0, 0, 1);
      acc("R4", 'h0400_0000, 0, 1, 0);

      // R5: undefined codes
      wreg("R5", 'h31, 'h09);
      acc("R5", 'h0400_0000, 0, 0, 0);
      wreg("R5", 'h31, 'h0F);
      acc("R5", 'h0400_0000, 1, 0, 0);
      wreg("R5", 'h22, 'h06);
      acc("R5", 'h30000, 0, 0, 0);

      // R10: write and access in the same cycle use the old code
      step("R10", 1'b1, 'h31, 'h05, 1'b1, 'h0400_0000, 1'b0, 1'b1, 1'b0);
      acc("R10", 'h0400_0000, 0, 1, 0);
      acc("R10", 'h0400_0000, 0, 1, 0);
      rd("R10", 'h31);

      // R6: lock stores code and freezes register
      wreg("R6", 'h31, 'h82);
      rd("R6", 'h31);
      wreg("R6", 'h31, 'h05);
      rd("R6", 'h31);
      acc("R6", 'h0400_0000, 1, 1, 0);
      acc("R6", 'h0400_0000, 0, 1, 0);
      wreg("R6", 'h23, 'h80);
      wreg("R6", 'h23, 'h05);
      acc("R6", 'h40000, 1, 1, 0);

      // R3: unimplemented offsets
      wreg("R3", 'h32, 'hFF);
      rd("R3", 'h32); rd("R3", 'h00); rd("R3", 'h24); rd("R3", 'h2F);
      rd("R3", 'h30);

      // R6 / R1: reset clears lock
      do_reset();
      rd("R1", 'h31); rd("R1", 'h23);
      wreg("R6", 'h31, 'h05);
      rd("R6", 'h31);
      acc("R9", 'h40000, 1, 1, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule